// File: doc/BRIEF.md
# External Memory Bus Cycle Controller

This block runs one external read, write or code-fetch bus cycle at a time on behalf of a processor core. The core presents a request with an address, a write flag, a code/data flag, write data and three configuration fields: a two-bit active-low wait-state code, an address-latch-enable width select and a page/non-page select. The controller samples all of these when it accepts the request and then sequences the cycle on the external pins by itself.

Every cycle has three phases. It opens with an address phase, where the latch-enable pulse is high and both ports carry the full 16-bit address. A strobe phase follows, where exactly one of the read, write or program-store strobes is low for one base clock plus the wait states. The cycle ends with a one-clock done pulse. The page select decides which port is the data port. In page mode, port 2 multiplexes the high address byte with data and port 0 keeps the low address byte. In non-page mode, port 0 multiplexes the low address byte with data and port 2 keeps the high address byte. One clock of the controller is one oscillator period.

Top module: `ext_bus_ctrl`

## Requirements
- R1: The strobe stays low for 1 + N clocks. N is the number of wait states, decoded from the active-low code `ws_n_i`: 2'b00 gives N=3, 2'b01 gives N=2, 2'b10 gives N=1 and 2'b11 gives N=0.
- R2: The ALE pulse lasts 3 clocks when `ale_short_i`=0 and 1 clock when `ale_short_i`=1. The cycle after ALE falls is the first strobe cycle, and ALE is high in the first clock after acceptance.
- R3: While ALE is high, `p2_o` carries address bits 15:8, `p0_o` carries address bits 7:0, and both output enables are 1.
- R4: Page mode (`nopage_i`=0): during the strobe phase port 0 keeps driving address bits 7:0 with its enable at 1, and port 2 is the data port.
- R5: Non-page mode (`nopage_i`=1): during the strobe phase port 2 keeps driving address bits 15:8 with its enable at 1, and port 0 is the data port.
- R6: On a data write (`code_i`=0, `we_i`=1), `wr_no` is low through the strobe phase and the data port drives `wdata_i` with its enable at 1.
- R7: On a read (data read, or any code fetch), the data port enable is 0 during the strobe phase. `rdata_o` takes the data port input from the last strobe clock and keeps it until the next read completes. Writes leave it unchanged.
- R8: A code fetch (`code_i`=1) uses `psen_no` whatever the value of `we_i`. A data access uses `rd_no` or `wr_no` according to `we_i`. At most one strobe is low at a time, and none is low outside the strobe phase.
- R9: `done_o` is high for exactly one clock, the clock right after the last strobe clock, with all strobes high.
- R10: Address, write data, flags and configuration are taken at acceptance. Changes to them during the cycle have no effect on the pins.
- R11: A request is accepted only when the controller is idle. A request held high through a cycle, including its done clock, starts no extra cycle.
- R12: In reset and when idle, ALE and `done_o` are 0, all strobes are 1 and both port enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one oscillator period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Cycle request, taken when idle |
| we_i | input | 1 | 1 = write, 0 = read (data cycles) |
| code_i | input | 1 | 1 = code fetch via program-store strobe |
| addr_i | input | 16 | Cycle address |
| wdata_i | input | 8 | Write data |
| ws_n_i | input | 2 | Active-low wait-state code |
| ale_short_i | input | 1 | 1 = one-clock ALE, 0 = three-clock ALE |
| nopage_i | input | 1 | 1 = non-page mode, 0 = page mode |
| p0_i | input | 8 | Port 0 input pins |
| p2_i | input | 8 | Port 2 input pins |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| psen_no | output | 1 | Program-store strobe, active low |
| p0_o | output | 8 | Port 0 output value |
| p0_oe_o | output | 1 | Port 0 output enable |
| p2_o | output | 8 | Port 2 output value |
| p2_oe_o | output | 1 | Port 2 output enable |
| rdata_o | output | 8 | Last read data |
| done_o | output | 1 | One-clock end-of-cycle pulse |

## Verification
The assertions assume that reset is applied before the first request. They also assume that the external device never needs the controller to drive a port while a strobe is low on a read. They do not assume that the request or configuration inputs stay still during a cycle. The stimulus therefore holds the request high through each entire cycle and inverts every sampled input right after acceptance. It sweeps all wait codes, both ALE widths, both port modes and the three access kinds. The port inputs change on every clock, so a capture taken on the wrong clock shows up as a wrong value.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;
  localparam int WS_W   = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_ALE, ST_STRB, ST_DONE} bus_st_e;

  typedef struct packed {
    logic              we;
    logic              code;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [WS_W-1:0]   ws_n;
    logic              ale_short;
    logic              nopage;
  } bus_cyc_t;
endpackage

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_pkg::*;
#(
  parameter int ALE_LONG = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  bus_cyc_t cyc_i,
  output bus_st_e  st_o,
  output bus_cyc_t cyc_o,
  output logic     last_strb_o
);
  localparam int WS_MAX  = (1 << WS_W) - 1;
  localparam int CNT_MAX = (ALE_LONG - 1 > WS_MAX) ? ALE_LONG - 1 : WS_MAX;
  localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

  bus_st_e          st_q;
  bus_cyc_t         cyc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WS_W-1:0]  ws_val;

  assign ws_val = ~cyc_q.ws_n;  // active-low code -> wait count

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cyc_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          cyc_q <= cyc_i;
          st_q  <= ST_ALE;
          cnt_q <= cyc_i.ale_short ? '0 : CNT_W'(ALE_LONG - 1);
        end
        ST_ALE: if (cnt_q == '0) begin
          st_q  <= ST_STRB;
          cnt_q <= CNT_W'(ws_val);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_STRB: if (cnt_q == '0) st_q <= ST_DONE;
                 else cnt_q <= cnt_q - 1'b1;
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o        = st_q;
  assign cyc_o       = cyc_q;
  assign last_strb_o = (st_q == ST_STRB) && (cnt_q == '0);

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(cyc_q)); // R10
  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE) |=> (st_q == ST_IDLE)); // R11
endmodule

// File: rtl/ext_bus_mux.sv
module ext_bus_mux
  import ext_bus_pkg::*;
(
  input  bus_st_e           st_i,
  input  logic              we_i,
  input  logic              code_i,
  input  logic              nopage_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              psen_no,
  output logic [DATA_W-1:0] p0_o,
  output logic              p0_oe_o,
  output logic [DATA_W-1:0] p2_o,
  output logic              p2_oe_o
);
  logic strb, drv;

  assign strb = (st_i == ST_STRB);
  assign drv  = we_i && !code_i;  // only data writes drive the data port

  assign ale_o   = (st_i == ST_ALE);
  assign psen_no = !(strb && code_i);
  assign rd_no   = !(strb && !code_i && !we_i);
  assign wr_no   = !(strb && !code_i && we_i);

  always_comb begin
    p0_o    = '0;
    p2_o    = '0;
    p0_oe_o = 1'b0;
    p2_oe_o = 1'b0;
    unique case (st_i)
      ST_ALE: begin
        p0_o    = addr_i[DATA_W-1:0];
        p2_o    = addr_i[ADDR_W-1:DATA_W];
        p0_oe_o = 1'b1;
        p2_oe_o = 1'b1;
      end
      ST_STRB: begin
        if (nopage_i) begin
          p2_o    = addr_i[ADDR_W-1:DATA_W];
          p2_oe_o = 1'b1;
          p0_o    = drv ? wdata_i : '0;
          p0_oe_o = drv;
        end else begin
          p0_o    = addr_i[DATA_W-1:0];
          p0_oe_o = 1'b1;
          p2_o    = drv ? wdata_i : '0;
          p2_oe_o = drv;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ext_bus_cap.sv
module ext_bus_cap
  import ext_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ext_bus_pkg::*;
#(
  parameter int ALE_LONG = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              code_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WS_W-1:0]   ws_n_i,
  input  logic              ale_short_i,
  input  logic              nopage_i,
  input  logic [DATA_W-1:0] p0_i,
  input  logic [DATA_W-1:0] p2_i,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              psen_no,
  output logic [DATA_W-1:0] p0_o,
  output logic              p0_oe_o,
  output logic [DATA_W-1:0] p2_o,
  output logic              p2_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  bus_cyc_t          cyc_in, cyc;
  bus_st_e           st;
  logic              last_strb, cap_en;
  logic [DATA_W-1:0] data_in;

  assign cyc_in = '{we: we_i, code: code_i, addr: addr_i, wdata: wdata_i,
                    ws_n: ws_n_i, ale_short: ale_short_i, nopage: nopage_i};

  ext_bus_seq #(.ALE_LONG(ALE_LONG)) u_seq (
    .clk_i, .rst_ni, .req_i, .cyc_i(cyc_in),
    .st_o(st), .cyc_o(cyc), .last_strb_o(last_strb)
  );

  ext_bus_mux u_mux (
    .st_i(st), .we_i(cyc.we), .code_i(cyc.code), .nopage_i(cyc.nopage),
    .addr_i(cyc.addr), .wdata_i(cyc.wdata),
    .ale_o, .rd_no, .wr_no, .psen_no,
    .p0_o, .p0_oe_o, .p2_o, .p2_oe_o
  );

  assign data_in = cyc.nopage ? p0_i : p2_i;
  assign cap_en  = last_strb && (cyc.code || !cyc.we);

  ext_bus_cap u_cap (
    .clk_i, .rst_ni, .en_i(cap_en), .d_i(data_in), .q_o(rdata_o)
  );

  assign done_o = (st == ST_DONE);

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~rd_no, ~wr_no, ~psen_no}) <= 1); // R8
  AST_ALE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no && wr_no && psen_no)); // R8
  AST_STRB_AFTER_ALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> !(rd_no && wr_no && psen_no)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_AFTER_STRB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(!(rd_no && wr_no && psen_no))); // R9
  AST_READ_PORT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !psen_no) |-> (cyc.nopage ? !p0_oe_o : !p2_oe_o)); // R7
  AST_WRITE_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (p0_oe_o && p2_oe_o)); // R6
endmodule

// File: tb/ext_bus_ctrl_bench.sv
module ext_bus_ctrl_bench;
  import ext_bus_pkg::*;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req, we, code, ale_short, nopage;
  logic [15:0] addr;
  logic [7:0]  wdata, p0_in, p2_in;
  logic [1:0]  ws_n;
  logic ale, rd_n, wr_n, psen_n, p0_oe, p2_oe, done;
  logic [7:0] p0_out, p2_out, rdata;
  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] exp_rd = 8'h00;

  always #10 clk = ~clk;  // 50 MHz

  ext_bus_ctrl u_ext_bus_ctrl (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .code_i(code),
    .addr_i(addr), .wdata_i(wdata), .ws_n_i(ws_n), .ale_short_i(ale_short),
    .nopage_i(nopage), .p0_i(p0_in), .p2_i(p2_in),
    .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n), .psen_no(psen_n),
    .p0_o(p0_out), .p0_oe_o(p0_oe), .p2_o(p2_out), .p2_oe_o(p2_oe),
    .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_op(int wsc, bit sh, bit np, int op,
                        logic [15:0] a, logic [7:0] wd);
    int  na = sh ? 1 : 3;
    int  ns = 4 - wsc;          // R1: 1 + (3 - code)
    int  nt = na + ns + 1;
    bit  w  = (op != 0);
    bit  cd = (op == 2);
    bit  drv = w && !cd;
    @(negedge clk);
    req = 1'b1; we = w; code = cd; addr = a; wdata = wd;
    ws_n = wsc[1:0]; ale_short = sh; nopage = np;
    for (int j = 0; j <= nt; j++) begin
      bit e_ale, e_str, e_done, e_p0oe, e_p2oe;
      logic [7:0] e_p0, e_p2;
      @(negedge clk);
      if (j == 0) begin  // R10: scramble everything after acceptance
        we = ~w; code = ~cd; addr = ~a; wdata = ~wd;
        ws_n = ~wsc[1:0]; ale_short = ~sh; nopage = ~np;
      end
      if (j == nt - 1) req = 1'b0;  // R11: held through done clock
      e_ale  = (j < na);
      e_str  = (j >= na) && (j < na + ns);
      e_done = (j == na + ns);
      e_p0oe = e_ale || (e_str && (np ? drv : 1'b1));
      e_p2oe = e_ale || (e_str && (np ? 1'b1 : drv));
      e_p0   = (e_str && np) ? wd : a[7:0];
      e_p2   = (e_str && !np) ? wd : a[15:8];
      chk(e_ale ? "R2 R3 ctl" : e_str ? "R1 R8 R10 ctl" :
          e_done ? "R9 ctl" : "R11 R12 ctl",
          {25'd0, ale, rd_n, wr_n, psen_n, done, p0_oe, p2_oe},
          {25'd0, e_ale, !(e_str && !cd && !w), !(e_str && drv),
           !(e_str && cd), e_done, e_p0oe, e_p2oe});
      if (e_p0oe) chk(e_ale ? "R3 p0" : np ? "R6 R5 p0" : "R4 p0",
                      {24'd0, p0_out}, {24'd0, e_p0});
      if (e_p2oe) chk(e_ale ? "R3 p2" : np ? "R5 p2" : "R6 R4 p2",
                      {24'd0, p2_out}, {24'd0, e_p2});
      if (e_done) chk("R7 rdata", {24'd0, rdata}, {24'd0, exp_rd});
      p0_in = 8'h3C ^ 8'(j * 37);
      p2_in = 8'hA5 ^ 8'(j * 53);
      if (j == na + ns - 1 && !drv) exp_rd = np ? p0_in : p2_in;  // R7
    end
  endtask

  initial begin
    req = 0; we = 0; code = 0; addr = '0; wdata = '0; ws_n = '0;
    ale_short = 0; nopage = 0; p0_in = '0; p2_in = '0;
    repeat (3) @(negedge clk);
    chk("R12 reset", {25'd0, ale, rd_n, wr_n, psen_n, done, p0_oe, p2_oe},
        {25'd0, 7'b0111000});
    chk("R12 reset rdata", {24'd0, rdata}, 32'd0);
    rst_ni = 1'b1;
    for (int ws = 0; ws < 4; ws++)
      for (int sh = 0; sh < 2; sh++)
        for (int np = 0; np < 2; np++)
          for (int op = 0; op < 3; op++) begin
            int k = ((ws * 2 + sh) * 2 + np) * 3 + op;
            run_op(ws, sh[0], np[0], op, 16'h1234 + 16'(k * 16'h0F17),
                   8'h5A ^ 8'(k * 29));
          end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule